// File: doc/BRIEF.md
# Flash Controller Interrupt Unit

This block gathers five event sources of a flash memory controller into one interrupt request. Each source sets a sticky flag. Each flag is qualified by its own enable bit. A global enable input gates the combined result. Two of the sources come from level signals that the block turns into events. The first is the removable card's presence signal, where either edge means the card was inserted or removed. The second is the controller's running status, where only the drop from running to stopped counts. The other three sources arrive as single-cycle pulses.

Software uses a small register port with an address, a write strobe and write data. It reads, writes and clears through this port. Flags clear only when software writes a one to them. The block also reports the level of the card's write-lock input as a status bit. The card-detect and lock inputs are asynchronous, so each passes through a two-flop synchronizer. The remaining inputs and the register port are synchronous to `clk`. The register port is plain control, with no handshake: a write takes effect at the next rising edge, and read data is a combinational function of the address.

Top module: `flash_irq_unit`

## Requirements
- R1: The flag register is at address 0. Its bit positions are: stop at bit 0, ECC-error at bit 1, ECC-ready at bit 2, illegal-operation at bit 3 and card-change at bit 4. Bits 7..5 read 0. A one-cycle pulse on `ev_ecc_err_i`, `ev_ecc_rdy_i` or `ev_illegal_i` sets that source's flag at the next rising edge.
- R2: The stop flag (bit 0) is set one edge after `run_i` falls from 1 to 0. A rising `run_i` sets nothing.
- R3: A change of `card_det_i` in either direction sets the card-change flag (bit 4). The flag becomes visible after the third rising edge that follows the change, because of two synchronizer stages and one edge stage.
- R4: A set flag stays set, over any number of cycles, until software clears it.
- R5: A write to address 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R6: When a source's event and the clear of its flag fall in the same cycle, the flag ends that cycle set.
- R7: The enable register is at address 1. Its bits 4..0 use the same bit positions as the flags, are written directly, and read back. Bits 7..5 read 0.
- R8: `irq_o` is 1 exactly when `glb_irq_en_i` is 1 and at least one flag is set together with its enable bit.
- R9: Address 2 reads the synchronized level of `card_lock_i` at bit 6, two edges after the input changes. All its other bits read 0, and so does address 3.
- R10: While `rst_n` is low at a rising edge, all flags and enables are cleared. Whatever input levels are present during reset, leaving reset creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| card_det_i | input | 1 | Card presence level (asynchronous) |
| card_lock_i | input | 1 | Card write-lock level, high with no card (asynchronous) |
| run_i | input | 1 | Controller running status |
| ev_illegal_i | input | 1 | Illegal-operation pulse |
| ev_ecc_rdy_i | input | 1 | ECC-ready pulse |
| ev_ecc_err_i | input | 1 | ECC-error pulse |
| glb_irq_en_i | input | 1 | Global interrupt enable |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a flag rises only after an event for it;
- a flag without a clear stays set, and a clear without an event empties it;
- an event wins over a clear in the same cycle;
- the stop flag rises only after a falling `run_i`;
- the request follows its gating.

The synchronizer delays of the card and lock inputs, the bit positions at each address and the quiet exit from reset are shown only by the bench's scenarios. The bench compares every read and every request against a cycle model. It also drives directed sequences for each edge direction and for a clear that collides with an event.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int NSRC     = 5;
  localparam int REG_W    = 8;
  localparam int LOCK_POS = 6;

  localparam int B_STOP    = 0;
  localparam int B_ECCERR  = 1;
  localparam int B_ECCRDY  = 2;
  localparam int B_ILLEGAL = 3;
  localparam int B_CARD    = 4;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) st[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) st[s] <= st[s-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/evt_edge.sv
module evt_edge #(
  parameter bit BOTH_EDGES = 1'b1
) (
  input  logic clk,
  input  logic din,
  output logic pulse
);
  logic prev_q;

  // Follows the input also during reset, so leaving reset makes no edge.
  always_ff @(posedge clk) prev_q <= din;

  if (BOTH_EDGES) begin : g_both
    assign pulse = din ^ prev_q;
  end else begin : g_fall
    assign pulse = prev_q & ~din;
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_rise_needs_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[i]) |-> $past(set_i[i]));
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_q[i]);
  end
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
  import flash_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_det_i,
  input  logic             card_lock_i,
  input  logic             run_i,
  input  logic             ev_illegal_i,
  input  logic             ev_ecc_rdy_i,
  input  logic             ev_ecc_err_i,
  input  logic             glb_irq_en_i,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int PAD_W = REG_W - NSRC;

  logic            card_s, lock_s;
  logic            card_evt, stop_evt;
  logic [NSRC-1:0] set_v, clr_v, flag_q, en_q;

  sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({card_lock_i, card_det_i}),
    .q   ({lock_s, card_s})
  );

  evt_edge #(.BOTH_EDGES(1'b1)) u_card_edge (
    .clk (clk), .din (card_s), .pulse (card_evt)
  );

  evt_edge #(.BOTH_EDGES(1'b0)) u_run_edge (
    .clk (clk), .din (run_i), .pulse (stop_evt)
  );

  always_comb begin
    set_v            = '0;
    set_v[B_STOP]    = stop_evt;
    set_v[B_ECCERR]  = ev_ecc_err_i;
    set_v[B_ECCRDY]  = ev_ecc_rdy_i;
    set_v[B_ILLEGAL] = ev_illegal_i;
    set_v[B_CARD]    = card_evt;
  end

  assign clr_v = (reg_wr_i && reg_addr_i == ADDR_FLAG) ? reg_wdata_i[NSRC-1:0] : '0;

  flag_bank #(.N(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .flags_o (flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                  en_q <= '0;
    else if (reg_wr_i && reg_addr_i == ADDR_MASK) en_q <= reg_wdata_i[NSRC-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_FLAG: reg_rdata_o = {{PAD_W{1'b0}}, flag_q};
      ADDR_MASK: reg_rdata_o = {{PAD_W{1'b0}}, en_q};
      ADDR_STAT: reg_rdata_o[LOCK_POS] = lock_s;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = glb_irq_en_i & (|(flag_q & en_q));

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:NSRC];

  assert_stop_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[B_STOP]) |-> $past($fell(run_i)));
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_irq_en_i |-> !irq_o);
  assert_enabled_flag_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_irq_en_i && |(flag_q & en_q)) |-> irq_o);
endmodule

// File: tb/flash_irq_unit_bench.sv
module flash_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card = 1'b0, lock = 1'b1, run = 1'b1;
  logic       ill = 1'b0, rdy = 1'b0, err = 1'b0, glb = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0] m_flags = 0, m_en = 0;
  logic m_c1 = 0, m_c2 = 0, m_cp = 0, m_l1 = 1, m_l2 = 1, m_rp = 1;

  always #5 clk = ~clk;

  flash_irq_unit u_flash_irq_unit (
    .clk(clk), .rst_n(rst_n), .card_det_i(card), .card_lock_i(lock), .run_i(run),
    .ev_illegal_i(ill), .ev_ecc_rdy_i(rdy), .ev_ecc_err_i(err), .glb_irq_en_i(glb),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {3'b000, m_flags};
      2'd1: return {3'b000, m_en};
      2'd2: return {1'b0, m_l2, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return glb & (|(m_flags & m_en));
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [4:0] set_v, clr_v;
    if (!rst_n) begin
      m_flags = 0; m_en = 0;
    end else begin
      set_v = {m_c2 ^ m_cp, ill, rdy, err, m_rp & ~run};
      clr_v = (wr && addr == 2'd0) ? wdata[4:0] : 5'd0;
      m_flags = (m_flags & ~clr_v) | set_v;
      if (wr && addr == 2'd1) m_en = wdata[4:0];
    end
    m_cp = m_c2; m_c2 = m_c1; m_c1 = card;
    m_l2 = m_l1; m_l1 = lock; m_rp = run;
  endtask

  task automatic tick();
    string tag;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (rst_n) begin
      case (addr)
        2'd0: tag = "R1";
        2'd1: tag = "R7";
        default: tag = "R9";
      endcase
      check(tag, rdata, exp_read(addr));
      check("R8", {7'd0, irq}, {7'd0, exp_irq()});
    end
  endtask

  task automatic quiet();
    ill = 0; rdy = 0; err = 0; wr = 0; wdata = 0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) tick();
    rst_n = 1;
    tick();
    // R10: no flags, no enables, no request after reset, card low and running high
    check("R10 flags", rdata, 8'h00);
    addr = 2'd1; #1 check("R10 enables", rdata, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h00);
    addr = 2'd0; glb = 1;

    // R2: falling run sets stop, rising does not
    run = 0; tick();
    check("R2 fall", rdata, 8'h01);
    wr = 1; wdata = 8'h01; tick(); quiet();
    run = 1; tick(); tick();
    check("R2 rise", rdata, 8'h00);

    // R3: insertion then removal, three edges of latency
    card = 1; tick(); tick();
    check("R3 early", rdata, 8'h00);
    tick();
    check("R3 insert", rdata, 8'h10);
    wr = 1; wdata = 8'h10; tick(); quiet();
    card = 0; tick(); tick(); tick();
    check("R3 remove", rdata, 8'h10);
    wr = 1; wdata = 8'h1F; tick(); quiet();

    // R6: event and clear in the same cycle
    ill = 1; wr = 1; wdata = 8'h08; tick(); quiet();
    check("R6", rdata, 8'h08);
    // R5: clearing one bit leaves the other
    err = 1; tick(); quiet();
    check("R1 ecc err", rdata, 8'h0A);
    wr = 1; wdata = 8'h08; tick(); quiet();
    check("R5", rdata, 8'h02);
    // R4: remains set
    repeat (20) tick();
    check("R4", rdata, 8'h02);

    // R7: enable register width
    addr = 2'd1; wr = 1; wdata = 8'hFF; tick(); quiet();
    check("R7", rdata, 8'h1F);
    // R8: gating
    glb = 0; #1 check("R8 gate off", {7'd0, irq}, 8'h00);
    glb = 1; #1 check("R8 gate on", {7'd0, irq}, 8'h01);
    wr = 1; wdata = 8'h1D; tick(); quiet();
    check("R8 masked", {7'd0, irq}, 8'h00);

    // R9: lock level through two stages
    addr = 2'd2; lock = 0; tick();
    check("R9 held", rdata, 8'h40);
    tick();
    check("R9 low", rdata, 8'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      ill = ($urandom % 8) == 0;
      rdy = ($urandom % 8) == 0;
      err = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) run = ~run;
      if (($urandom % 10) == 0) card = ~card;
      if (($urandom % 7) == 0) lock = ~lock;
      if (($urandom % 16) == 0) glb = ~glb;
      addr = 2'($urandom);
      wr = ($urandom % 4) == 0;
      wdata = 8'($urandom);
      tick();
    end
    quiet();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule